// File: doc/BRIEF.md
# Sleep Mode Clock Controller

This block governs two low-power states of a small 8-bit microcontroller core. It watches the decoded instruction stream for two sleep opcodes and then gates the clocks. A light sleep (state LIGHT) stops only the CPU clock. The oscillator and the peripheral clock keep running, so the timers and the external interrupt inputs stay alive. A deep sleep (state DEEP) stops the CPU clock, the peripheral clock and the oscillator.

Light sleep ends when the interrupt controller reports an enabled request that it is servicing. The core then resumes in line, with no restart. Deep sleep ends in one of two ways: a power-on reset, or a low level on a dedicated wake pin.

On the way out of deep sleep the oscillator is switched back on first. The CPU clock stays off for a parameterised settling count (state SETTLE). The block then issues a one-cycle restart request carrying the fixed restart vector (state RESTART). Alongside the request it gives a flag that says whether the port mode registers must return to their power-on defaults. That flag is set after a reset and clear after a pin wake. The state after reset is SETTLE.

Named transitions:
- RUN to LIGHT: light opcode that follows a NOP.
- RUN to DEEP: deep opcode that follows a NOP, with the pin high.
- RUN to SETTLE: deep opcode that follows a NOP, with the pin already low.
- LIGHT to RUN: serviced interrupt.
- DEEP to SETTLE: pin low.
- SETTLE to RESTART: settling count reached.
- RESTART to RUN: always, after one cycle.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: After reset is released the block holds cpu_clk_en=0, per_clk_en=0 and osc_en=1 for STAB_CYC (default 16) cycles. It then pulses restart_req for one cycle, and then runs with cpu_clk_en=per_clk_en=osc_en=1.
- R2: A valid opcode 8'h7F whose preceding valid opcode was 8'hFF enters light sleep from the next cycle on. In light sleep cpu_clk_en=0, per_clk_en=1 and osc_en=1.
- R3: Light sleep is left only when irq_take=1. In the next cycle cpu_clk_en=1, and no restart_req is raised.
- R4: A valid opcode 8'h6F whose preceding valid opcode was 8'hFF, with wake_pin=1, enters deep sleep from the next cycle on. In deep sleep cpu_clk_en, per_clk_en and osc_en are all 0.
- R5: Deep sleep holds for as long as wake_pin=1. With wake_pin=0, osc_en rises in the next cycle while cpu_clk_en stays 0 for STAB_CYC cycles.
- R6: restart_req lasts exactly one cycle, with cpu_clk_en=per_clk_en=osc_en=1. restart_vec equals 16'h000C during that cycle and 0 at all other times.
- R7: port_cfg_reset is 1 only together with a restart_req that follows a reset. It is 0 on the restart after a wake-pin exit.
- R8: A sleep opcode whose preceding valid opcode was not 8'hFF is ignored. Cycles with op_valid=0 between the NOP and the sleep opcode do not break the pairing.
- R9: If wake_pin=0 when an accepted deep opcode executes, the block goes directly to settling, and osc_en never drops.
- R10: A NOP and sleep opcode pair that arrives while a sleep state is active is ignored. The block stays in the current sleep state with unchanged enables.
- R11: irq_take has no effect during deep sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock of the controller |
| rst_n | input | 1 | Active-low power-on reset |
| op_code | input | 8 | Decoded opcode at an instruction boundary |
| op_valid | input | 1 | op_code is valid this cycle |
| irq_take | input | 1 | Enabled interrupt request being serviced |
| wake_pin | input | 1 | Wake pin level, low wakes deep sleep (synchronous to clk) |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Timer and interrupt-logic clock enable |
| osc_en | output | 1 | Oscillator enable |
| restart_req | output | 1 | One-cycle program counter restart request |
| restart_vec | output | ADDR_W | Restart address, valid with restart_req |
| port_cfg_reset | output | 1 | Port mode registers must return to defaults |

## Verification
Every state drives a distinct combination of the three enables and the restart request. A wrong state therefore shows at the ports in the cycle after the faulty transition.

A lost NOP pairing shows up as sleep entry or its absence one cycle after the opcode. A wrong settling count moves the restart pulse early or late by the size of the error. A wrong wake-source record flips port_cfg_reset in the restart cycle itself.

// File: rtl/slpc_pkg.sv
package slpc_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_LIGHT,
        ST_DEEP,
        ST_SETTLE,
        ST_RESTART
    } slpc_state_e;

    localparam logic [7:0] OPC_NOP   = 8'hFF;
    localparam logic [7:0] OPC_LIGHT = 8'h7F;
    localparam logic [7:0] OPC_DEEP  = 8'h6F;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
        logic req;
    } slpc_en_s;

endpackage

// File: rtl/slpc_opdec.sv
module slpc_opdec
    import slpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [7:0] op_code,
    output logic       light_req,
    output logic       deep_req
);

    // Remembers whether the most recent valid opcode flushed the pipeline.
    logic prev_nop_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_nop_q <= 1'b0;
        end else if (op_valid) begin
            prev_nop_q <= (op_code == OPC_NOP);
        end
    end

    always_comb begin
        light_req = op_valid && prev_nop_q && (op_code == OPC_LIGHT);
        deep_req  = op_valid && prev_nop_q && (op_code == OPC_DEEP);
    end

endmodule

// File: rtl/slpc_settle_tmr.sv
module slpc_settle_tmr #(
    parameter int unsigned STAB_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int unsigned CNT_W = (STAB_CYC < 2) ? 1 : $clog2(STAB_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == LAST);

    // R5: the count never runs past the settling window
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= LAST));

endmodule

// File: rtl/slpc_fsm.sv
module slpc_fsm
    import slpc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     light_req,
    input  logic     deep_req,
    input  logic     irq_take,
    input  logic     wake_n,
    input  logic     settle_done,
    output logic     settling,
    output slpc_en_s en,
    output logic     cfg_reset
);

    slpc_state_e st_q, st_d;
    logic        src_rst_q, src_rst_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_SETTLE;
            src_rst_q <= 1'b1;
        end else begin
            st_q      <= st_d;
            src_rst_q <= src_rst_d;
        end
    end

    always_comb begin
        st_d      = st_q;
        src_rst_d = src_rst_q;
        unique case (st_q)
            ST_RUN: begin
                if (deep_req) begin
                    if (!wake_n) begin
                        st_d      = ST_SETTLE;
                        src_rst_d = 1'b0;
                    end else begin
                        st_d = ST_DEEP;
                    end
                end else if (light_req) begin
                    st_d = ST_LIGHT;
                end
            end
            ST_LIGHT: begin
                if (irq_take) st_d = ST_RUN;
            end
            ST_DEEP: begin
                if (!wake_n) begin
                    st_d      = ST_SETTLE;
                    src_rst_d = 1'b0;
                end
            end
            ST_SETTLE: begin
                if (settle_done) st_d = ST_RESTART;
            end
            ST_RESTART: begin
                st_d = ST_RUN;
            end
            default: st_d = ST_RUN;
        endcase
    end

    always_comb begin
        en        = '0;
        cfg_reset = 1'b0;
        settling  = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                en.cpu = 1'b1;
                en.per = 1'b1;
                en.osc = 1'b1;
            end
            ST_LIGHT: begin
                en.per = 1'b1;
                en.osc = 1'b1;
            end
            ST_DEEP: begin
                en = '0;
            end
            ST_SETTLE: begin
                en.osc   = 1'b1;
                settling = 1'b1;
            end
            ST_RESTART: begin
                en        = '1;
                cfg_reset = src_rst_q;
            end
            default: en = '0;
        endcase
    end

    // R10: a sleep request while already asleep leaves the state unchanged
    assert_sleep_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_LIGHT || st_q == ST_DEEP) && !irq_take && wake_n)
        |=> $stable(st_q));

endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
    import slpc_pkg::*;
#(
    parameter int unsigned STAB_CYC = 16,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned RST_VEC  = 'h000C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        op_code,
    input  logic              op_valid,
    input  logic              irq_take,
    input  logic              wake_pin,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              osc_en,
    output logic              restart_req,
    output logic [ADDR_W-1:0] restart_vec,
    output logic              port_cfg_reset
);

    localparam logic [ADDR_W-1:0] VEC = ADDR_W'(RST_VEC);

    logic     light_req, deep_req;
    logic     settling, settle_done;
    slpc_en_s en;
    logic     cfg_reset;

    slpc_opdec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .light_req (light_req),
        .deep_req  (deep_req)
    );

    slpc_settle_tmr #(.STAB_CYC(STAB_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (settling),
        .done  (settle_done)
    );

    slpc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .light_req   (light_req),
        .deep_req    (deep_req),
        .irq_take    (irq_take),
        .wake_n      (wake_pin),
        .settle_done (settle_done),
        .settling    (settling),
        .en          (en),
        .cfg_reset   (cfg_reset)
    );

    assign cpu_clk_en     = en.cpu;
    assign per_clk_en     = en.per;
    assign osc_en         = en.osc;
    assign restart_req    = en.req;
    assign restart_vec    = en.req ? VEC : '0;
    assign port_cfg_reset = cfg_reset;

    // R3: light sleep persists until a serviced interrupt
    assert_light_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && per_clk_en && !irq_take) |=> (!cpu_clk_en && per_clk_en));

    // R5 / R11: oscillator stays off while the wake pin is high
    assert_deep_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && wake_pin) |=> !osc_en);

    // R5: restart only follows a cycle of running oscillator with CPU gated
    assert_settle_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restart_req) |-> ($past(osc_en) && !$past(cpu_clk_en)));

    // R6: restart request is a single-cycle pulse
    assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req);

    // R7: the port default flag never appears without a restart
    assert_cfg_with_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        port_cfg_reset |-> restart_req);

endmodule

// File: tb/sleep_clk_ctrl_test.sv
`timescale 1ns/1ps
module sleep_clk_ctrl_test;

    localparam int STAB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic        op_valid = 1'b0;
    logic        irq_take = 1'b0;
    logic        wake_pin = 1'b1;
    logic        cpu_clk_en, per_clk_en, osc_en, restart_req, port_cfg_reset;
    logic [15:0] restart_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sleep_clk_ctrl uut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_valid(op_valid),
        .irq_take(irq_take), .wake_pin(wake_pin), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en), .restart_req(restart_req),
        .restart_vec(restart_vec), .port_cfg_reset(port_cfg_reset)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ens();
        return {cpu_clk_en, per_clk_en, osc_en, restart_req};
    endfunction

    task automatic send(input logic [7:0] op);
        op_code  = op;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        op_code  = 8'h00;
    endtask

    // Called at the first negedge where settling is visible.
    task automatic settle_restart(input string tag, input logic cfg_exp);
        chk({tag, " R5 settle start"}, 32'(ens()), 32'b0010);
        repeat (STAB - 1) @(negedge clk);
        chk({tag, " R5 settle end"}, 32'(ens()), 32'b0010);
        @(negedge clk);
        chk({tag, " R6 restart"}, 32'(ens()), 32'b1111);
        chk({tag, " R6 vector"}, 32'(restart_vec), 32'h000C);
        chk({tag, " R7 cfg flag"}, 32'(port_cfg_reset), 32'(cfg_exp));
        @(negedge clk);
        chk({tag, " R6 back to run"}, 32'(ens()), 32'b1110);
        chk({tag, " R6 vector idle"}, 32'(restart_vec), 32'h0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset state", 32'(ens()), 32'b0010);
        settle_restart("R1 power-up", 1'b1);
    endtask

    task automatic t_light();
        send(8'hFF);
        send(8'h7F);
        chk("R2 light entry", 32'(ens()), 32'b0110);
        repeat (5) @(negedge clk);
        chk("R3 light holds", 32'(ens()), 32'b0110);
        irq_take = 1'b1;
        @(negedge clk);
        irq_take = 1'b0;
        chk("R3 light exit in line", 32'(ens()), 32'b1110);
    endtask

    task automatic t_nop_guard();
        send(8'h7F);
        chk("R8 light without NOP", 32'(ens()), 32'b1110);
        send(8'h12);
        send(8'h6F);
        chk("R8 deep without NOP", 32'(ens()), 32'b1110);
        send(8'hFF);
        @(negedge clk);
        send(8'h7F);
        chk("R8 idle gap keeps pairing", 32'(ens()), 32'b0110);
        irq_take = 1'b1;
        @(negedge clk);
        irq_take = 1'b0;
        chk("R3 exit after gap", 32'(ens()), 32'b1110);
    endtask

    task automatic t_deep_pin();
        send(8'hFF);
        send(8'h6F);
        chk("R4 deep entry", 32'(ens()), 32'b0000);
        irq_take = 1'b1;
        @(negedge clk);
        irq_take = 1'b0;
        chk("R11 irq ignored in deep", 32'(ens()), 32'b0000);
        repeat (4) @(negedge clk);
        chk("R5 deep holds with pin high", 32'(ens()), 32'b0000);
        wake_pin = 1'b0;
        @(negedge clk);
        settle_restart("R5 pin wake", 1'b0);
        wake_pin = 1'b1;
    endtask

    task automatic t_nested();
        send(8'hFF);
        send(8'h7F);
        send(8'hFF);
        send(8'h6F);
        chk("R10 deep op in light", 32'(ens()), 32'b0110);
        irq_take = 1'b1;
        @(negedge clk);
        irq_take = 1'b0;
        send(8'hFF);
        send(8'h6F);
        send(8'hFF);
        send(8'h7F);
        chk("R10 light op in deep", 32'(ens()), 32'b0000);
        wake_pin = 1'b0;
        @(negedge clk);
        settle_restart("R10 wake", 1'b0);
        wake_pin = 1'b1;
    endtask

    task automatic t_low_entry();
        wake_pin = 1'b0;
        send(8'hFF);
        send(8'h6F);
        chk("R9 osc kept on", 32'(osc_en), 32'h1);
        settle_restart("R9 immediate", 1'b0);
        wake_pin = 1'b1;
    endtask

    task automatic t_reset_deep();
        send(8'hFF);
        send(8'h6F);
        chk("R4 deep before reset", 32'(ens()), 32'b0000);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        settle_restart("R7 reset wake", 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_light();
        t_nop_guard();
        t_deep_pin();
        t_nested();
        t_low_entry();
        t_reset_deep();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule